// File: doc/BRIEF.md
# Free-Running System Timer with Compare Channels

This block is a free-running 64-bit time base with four 32-bit compare channels. A prescaler divides the system clock down to a 1 MHz tick enable, and the counter advances by one on every tick. Each channel holds a compare value. When the low word of the counter steps onto that value, the channel raises a sticky match flag, and that flag drives the channel's interrupt line directly.

Software reaches the block through a simple word-addressed register port. There is one shared status word with one match flag per channel, the two counter words and the four compare words. A flag is acknowledged by writing a one to its bit. A periodic interrupt is built in software. The handler acknowledges the flag and then loads the compare word with the current low count plus the period. There is no hardware reload.

A 64-bit value cannot be read in one access through a 32-bit port. Reading the low word therefore captures the high word in a shadow register, and the next high-word read returns that captured value. The two halves then form one consistent sample.

Top module: `systmr_top`

## Requirements
- R1: During reset the counter is loaded with the RESET_COUNT parameter, and all flags, compare words, read data and interrupt lines are cleared to zero.
- R2: The tick enable fires once every CLK_HZ/TICK_HZ system clocks. The 64-bit counter grows by exactly one per tick and holds its value otherwise.
- R3: A channel's flag is set by the tick in which the counter's low word becomes equal to that channel's compare word. The flag is not set at any other time.
- R4: A set flag stays set until software clears it. Interrupt line i always equals flag i.
- R5: Writing the status word (address 0) clears every flag whose data bit (bit i for channel i) is one. Zero bits have no effect. If a clear and a new match of the same channel fall in the same cycle, the flag ends up set.
- R6: Writes to the counter low word (address 1) and counter high word (address 2) are ignored.
- R7: A read returns its data on rd_data in the cycle after rd_en. The address map is: 0 is status, with flags in bits 3:0 and zero above; 1 is the counter low word; 2 is the counter high word; 3 to 6 are compare 0 to 3. Address 7 reads as zero.
- R8: Reading the low word captures the high word of the same instant. A later high-word read returns that captured value, even if the counter has carried since then.
- R9: A carry out of the low word increments the high word.
- R10: Compare words are written at addresses 3 to 6 and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| irq | output | 4 | Per-channel interrupt lines, equal to the match flags |

## Verification
The checker watches several properties on every cycle. It checks that the tick is a single-cycle pulse and that the counter only ever steps by one. It checks that a flag rises only on a tick, that flags stay up unless the status word is written, and that a one-bit clear takes effect. It also checks that a low-word read returns the counter value of the previous cycle. Other behaviours only the bench scenarios can show. These are the exact tick spacing, that counter writes are ignored, the carry into the high word, the shadowed high-word read across a carry, and the same-cycle clash of a clear with a fresh match. The bench's reference model additionally compares read data and interrupt lines on every clock.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
  localparam int NCH    = 4;
  localparam int AW     = 3;
  localparam int DW     = 32;
  localparam logic [AW-1:0] ADR_STAT = 3'd0;
  localparam logic [AW-1:0] ADR_LO   = 3'd1;
  localparam logic [AW-1:0] ADR_HI   = 3'd2;
  localparam logic [AW-1:0] ADR_CMP0 = 3'd3;
endpackage

// File: rtl/systmr_prescale.sv
module systmr_prescale #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == W'(DIV - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick = (cnt_q == W'(DIV - 1));
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/systmr_count.sv
module systmr_count #(
  parameter logic [63:0] RESET_COUNT = 64'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  output logic [63:0] count,
  output logic [31:0] lo_next
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= RESET_COUNT;
    end else if (tick) begin
      count <= count + 64'd1;
    end
  end

  assign lo_next = count[31:0] + 32'd1;
endmodule

// File: rtl/systmr_chan.sv
module systmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [DW-1:0] lo_next,
  input  logic          cmp_we,
  input  logic [DW-1:0] cmp_wdata,
  input  logic          clr,
  output logic [DW-1:0] cmp,
  output logic          flag
);
  logic hit;

  assign hit = tick && (lo_next == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp  <= '0;
      flag <= 1'b0;
    end else begin
      if (cmp_we) cmp <= cmp_wdata;
      flag <= (flag && !clr) || hit;
    end
  end
endmodule

// File: rtl/systmr_top.sv
module systmr_top
  import systmr_pkg::*;
#(
  parameter int          CLK_HZ      = 200_000_000,
  parameter int          TICK_HZ     = 1_000_000,
  parameter logic [63:0] RESET_COUNT = 64'd0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [NCH-1:0] irq
);
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic          tick;
  logic [63:0]   count;
  logic [31:0]   lo_next;
  logic [31:0]   hi_shadow;
  logic [NCH-1:0] flags;
  logic [DW-1:0] cmp_q [NCH];

  systmr_prescale #(.DIV(DIV)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  systmr_count #(.RESET_COUNT(RESET_COUNT)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .count  (count),
    .lo_next(lo_next)
  );

  logic stat_we;
  assign stat_we = wr_en && (addr == ADR_STAT);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic we_i;
      assign we_i = wr_en && (addr == AW'(int'(ADR_CMP0) + i));
      systmr_chan #(.DW(DW)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .lo_next  (lo_next),
        .cmp_we   (we_i),
        .cmp_wdata(wr_data),
        .clr      (stat_we && wr_data[i]),
        .cmp      (cmp_q[i]),
        .flag     (flags[i])
      );
    end
  endgenerate

  assign irq = flags;

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_STAT: rd_mux = DW'(flags);
      ADR_LO:   rd_mux = count[31:0];
      ADR_HI:   rd_mux = hi_shadow;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (addr == AW'(int'(ADR_CMP0) + i)) rd_mux = cmp_q[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      hi_shadow <= '0;
    end else if (rd_en) begin
      rd_data <= rd_mux;
      if (addr == ADR_LO) hi_shadow <= count[63:32];
    end
  end
endmodule

// File: rtl/systmr_chk.sv
module systmr_chk #(
  parameter int NCH = 4,
  parameter int DIV = 200
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           rd_en,
  input logic [2:0]     addr,
  input logic [NCH-1:0] wr_bits,
  input logic [31:0]    rd_data,
  input logic [NCH-1:0] irq,
  input logic           tick,
  input logic [63:0]    count
);
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
    (DIV > 1) && tick |=> !tick); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + 64'd1)); // R2

  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(irq)) != '0) |-> $past(tick)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 3'd0) |=> ((irq & $past(irq)) == $past(irq))); // R4

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0 && !tick) |=> ((irq & $past(wr_bits)) == '0)); // R5

  AST_LO_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd1) |=> (rd_data == $past(count[31:0]))); // R7
endmodule

bind systmr_top systmr_chk #(.NCH(systmr_pkg::NCH), .DIV(CLK_HZ / TICK_HZ)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wr_bits(wr_data[systmr_pkg::NCH-1:0]),
  .rd_data(rd_data),
  .irq    (irq),
  .tick   (tick),
  .count  (count)
);

// File: tb/tb_systmr_top.sv
`timescale 1ns/1ps
module tb_systmr_top;
  localparam int          CLK_HZ = 8_000_000;
  localparam int          TICK_HZ = 1_000_000;
  localparam int          DIV = CLK_HZ / TICK_HZ;
  localparam logic [63:0] RST_CNT = 64'h0000_0000_FFFF_FF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  systmr_top #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .RESET_COUNT(RST_CNT)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int          m_pre;
  logic [63:0] m_cnt;
  logic [3:0]  m_fl;
  logic [31:0] m_cmp [4];
  logic [31:0] m_hil;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cnt = RST_CNT; m_fl = '0; m_hil = '0; m_rd = '0;
      for (int i = 0; i < 4; i++) m_cmp[i] = '0;
    end else begin
      bit tk;
      logic [3:0] nf;
      tk = (m_pre == DIV - 1);
      m_pre = tk ? 0 : m_pre + 1;
      if (rd_en) begin
        case (addr)
          3'd0: m_rd = {28'd0, m_fl};
          3'd1: begin m_rd = m_cnt[31:0]; m_hil = m_cnt[63:32]; end
          3'd2: m_rd = m_hil;
          3'd7: m_rd = '0;
          default: m_rd = m_cmp[addr - 3];
        endcase
      end
      nf = m_fl;
      if (wr_en && addr == 3'd0) nf = nf & ~wr_data[3:0];
      if (tk) begin
        for (int i = 0; i < 4; i++)
          if (m_cnt[31:0] + 32'd1 == m_cmp[i]) nf[i] = 1'b1;
        m_cnt = m_cnt + 64'd1;
      end
      m_fl = nf;
      if (wr_en && addr >= 3'd3 && addr <= 3'd6) m_cmp[addr - 3] = wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rd_data == m_rd, "R7 model rd_data", rd_data, m_rd);
      chk(irq == m_fl, "R4 model irq", irq, m_fl);
    end
  end

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, lo0, lo1;
    int n;
    repeat (4) @(negedge clk);
    chk(rd_data == 0, "R1 rd_data reset", rd_data, 0);
    chk(irq == 0, "R1 irq reset", irq, 0);
    rst = 1'b0;

    rd(3'd0, v);  chk(v == 0, "R1 status after reset", v, 0);
    rd(3'd4, v);  chk(v == 0, "R1 cmp1 after reset", v, 0);
    rd(3'd1, v);  chk(v >= 32'hFFFF_FF00 && v < 32'hFFFF_FF08, "R1 low word start", v, 32'hFFFF_FF00);

    // R10 compare write/read back
    wr(3'd6, 32'hA5A5_1234); rd(3'd6, v);
    chk(v == 32'hA5A5_1234, "R10 cmp3 readback", v, 32'hA5A5_1234);
    rd(3'd7, v);  chk(v == 0, "R7 unused address", v, 0);

    // R2 tick spacing and R6 ignored counter writes
    rd(3'd1, lo0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h1234);
    repeat (74) @(negedge clk);
    rd(3'd1, lo1);
    chk(lo1 - lo0 == 32'd10, "R2 ten ticks in 80 clocks", lo1 - lo0, 10);
    chk(lo1 > lo0, "R6 low write ignored", lo1, lo0);
    rd(3'd2, v);  chk(v == 0, "R6 high write ignored", v, 0);

    // R3 match on channel 1
    rd(3'd1, v);
    wr(3'd4, v + 32'd5);
    n = 0;
    while (!irq[1] && n < 100) begin @(negedge clk); n++; end
    chk(irq[1] == 1'b1, "R3 channel1 match", irq, 4'b0010);
    chk(n > 16, "R3 not early", n, 17);
    repeat (100) @(negedge clk);
    chk(irq[1] == 1'b1, "R4 flag sticky", irq, 4'b0010);
    rd(3'd0, v);  chk(v[1] == 1'b1, "R7 status bit1", v, 2);
    wr(3'd0, 32'h0);
    @(negedge clk);
    chk(irq[1] == 1'b1, "R5 zero write no effect", irq, 4'b0010);
    wr(3'd0, 32'h2);
    chk(irq[1] == 1'b0, "R5 one clears", irq, 0);

    // R3 periodic tick through software reprogram of channel 2
    for (int k = 0; k < 3; k++) begin
      rd(3'd1, v);
      wr(3'd5, v + 32'd3);
      n = 0;
      while (!irq[2] && n < 64) begin @(negedge clk); n++; end
      chk(irq[2] == 1'b1, "R3 periodic channel2", irq, 4'b0100);
      if (k < 2) wr(3'd0, 32'h4);
    end

    // R5 clear colliding with a new match: set wins
    wr(3'd0, 32'h4);
    rd(3'd1, v);
    wr(3'd5, v + 32'd2);
    n = 0;
    while (!irq[2] && n < 64) begin @(negedge clk); n++; end
    wr_en = 1'b1; addr = 3'd6; wr_data = m_cnt[31:0] + 32'd1;
    @(negedge clk); wr_en = 1'b0;
    repeat (6) @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wr_data = 32'h8;
    @(negedge clk); wr_en = 1'b0;
    chk(irq[3] == 1'b1, "R5 set wins over clear", irq, 4'b1000);
    wr(3'd0, 32'hF);
    chk(irq == 4'b0000, "R5 clear all", irq, 0);

    // R8 shadow across carry, R9 carry
    while (m_cnt[31:0] < 32'hFFFF_FFFC && m_cnt[63:32] == 0) @(negedge clk);
    rd(3'd1, v);
    while (m_cnt[63:32] == 0) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(3'd2, v);  chk(v == 0, "R8 high word from shadow", v, 0);
    rd(3'd1, v);  chk(v < 32'd8, "R9 low word wrapped", v, 0);
    rd(3'd2, v);  chk(v == 1, "R9 carry into high", v, 1);
    rd(3'd0, v);  chk(v[0] == 1'b1, "R3 channel0 match at zero", v, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule